// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous burst SRAM. Reads and writes can be mixed freely on consecutive clocks, and every cycle carries one data transfer. All control and address inputs are registered on the rising clock edge. Read data leaves through an output register two enabled cycles after its address. Write data follows its address by the same two enabled cycles. Because write data arrives late, the pending write addresses and byte lanes travel down a short pipeline. A read that targets a write still in flight is answered by merging in that write's data as it arrives.

A load cycle (`advLdIn` low) starts a new access, and its direction comes from `weN`. An advance cycle (`advLdIn` high) continues the last loaded access on the next address of a four-beat burst, in either linear or interleaved order. A low level on `cenN` qualifies each clock edge. The shared data bus is split into `dIn`, `dOut` and the drive enable `dOe`, and the asynchronous `oeN` gates that enable. A sleep input stops new accesses without disturbing the stored contents.

Top module: `pipe_sram`

## Requirements
- R1: A read loaded at enabled edge k shows its word on `dOut` after enabled edge k+2, with `dOe` high while `oeN` is low.
- R2: For a write loaded at enabled edge k, `dIn` is sampled at enabled edge k+2. Each lane i (bits 9i+8..9i) whose `bwN[i]` is 0 is stored, and each lane whose `bwN[i]` is 1 keeps its old value.
- R3: While `cenN` is high, the clock edge has no effect: `dOut`, `dOe`, the pending accesses and the memory all hold.
- R4: An access is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0 on a load cycle. Any other combination gives no write and a low `dOe` in its data slot.
- R5: `dOe` is low during the data slot of a write and during slots with no read.
- R6: Any sequence of reads and writes on consecutive enabled cycles returns, for every read, the value left by all writes loaded before it.
- R7: A read loaded one enabled cycle after a write to the same address returns the write's lanes merged over the old contents, according to the write's byte mask.
- R8: With `modeIlv`=0, the n-th advance after a load with low address bits s accesses low bits (s+n) mod 4, and the upper address bits are kept.
- R9: With `modeIlv`=1, the n-th advance accesses low bits s XOR n.
- R10: An advance cycle repeats the direction and selection of the last load and ignores the chip enables and `weN`. For writes, `bwN` is sampled on each advance cycle.
- R11: `oeN` high forces `dOe` low combinationally, with no clock edge needed.
- R12: While `zz` is high, no load or advance starts an access, and the stored data is kept.
- R13: After reset, `dOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| addrIn | input | ADDR_W (6) | Word address on load cycles |
| advLdIn | input | 1 | 0 = load a new access, 1 = advance the burst |
| weN | input | 1 | 0 = write, 1 = read, taken on load cycles |
| bwN | input | LANES (2) | Active-low byte lane write selects |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| cenN | input | 1 | Clock enable, active low |
| modeIlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oeN | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep: blocks new accesses |
| dIn | input | DATA_W (18) | Write data, bus input side |
| dOut | output | DATA_W (18) | Registered read data, bus output side |
| dOe | output | 1 | Bus drive enable |

## Verification
First, every address is filled with full-width writes. Directed runs then cover five cases, each aimed at one cause of a wrong result. A partial write followed at once by a read of the same address separates forwarding from a stale array read. Stalls with `cenN` inserted mid-pipeline, while address and data inputs toggle, separate a true hold from a leaking register. Each deselect pin pattern and sleep is applied on write attempts, which shows whether a blocked access still touches memory. Bursts in both orders, with the chip enables scrambled on advance cycles, show whether the address sequence and the retained direction are right. Finally, a long seeded random mix of loads, advances, stalls, deselects, sleep and `oeN` toggling is compared against an in-order memory model kept in the bench.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int ADDR_W  = 6;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int BURST_W = 2;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int DEPTH   = 1 << ADDR_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic              step;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  wrLanes;
    logic              fwdHit;
  } strobe_t;
endpackage

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advLdIn,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              cenN,
  input  logic              modeIlv,
  input  logic              zz,
  input  logic              oeN,
  output strobe_t           strb,
  output logic              dOe
);
  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } op_t;

  op_t st1, st2, nextOp;
  logic oeVld;
  logic [ADDR_W-1:0]  bBase;
  logic [BURST_W-1:0] bStart, bCnt, cntNext, seqLow;
  logic bWr, bSel;
  logic step, chipSel;

  assign step    = ~cenN;
  assign chipSel = ~ce1N & ce2 & ~ce3N;

  // Next access: new load or burst advance
  always_comb begin
    cntNext = bCnt + 1'b1;
    seqLow  = modeIlv ? (bStart ^ cntNext) : (bStart + cntNext);
    nextOp  = '0;
    if (!advLdIn) begin
      nextOp.vld  = chipSel & ~zz;
      nextOp.wr   = ~weN;
      nextOp.addr = addrIn;
    end else begin
      nextOp.vld  = bSel & ~zz;
      nextOp.wr   = bWr;
      nextOp.addr = {bBase[ADDR_W-1:BURST_W], seqLow};
    end
    nextOp.lanes = nextOp.wr ? ~bwN : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st1 <= '0; st2 <= '0; oeVld <= 1'b0;
      bBase <= '0; bStart <= '0; bCnt <= '0; bWr <= 1'b0; bSel <= 1'b0;
    end else if (step) begin
      st1   <= nextOp;
      st2   <= st1;
      oeVld <= st2.vld & ~st2.wr;
      if (!advLdIn) begin
        bBase  <= addrIn;
        bStart <= addrIn[BURST_W-1:0];
        bCnt   <= '0;
        bWr    <= ~weN;
        bSel   <= chipSel & ~zz;
      end else begin
        bCnt <= cntNext;
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.step    = step;
    strb.rdEn    = st1.vld & ~st1.wr;
    strb.rdAddr  = st1.addr;
    strb.wrEn    = st2.vld & st2.wr;
    strb.wrAddr  = st2.addr;
    strb.wrLanes = st2.lanes;
    strb.fwdHit  = st2.vld & st2.wr & st1.vld & ~st1.wr & (st2.addr == st1.addr);
  end

  assign dOe = oeVld & ~oeN;

  // R3: stalled edge leaves the pipeline untouched
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> ($stable(st1) && $stable(st2) && $stable(oeVld)));
  // R5: no drive in the data slot of a write
  a_r5_write_slot_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (step && st2.vld && st2.wr) |=> !dOe);
  // R4: a deselected load starts nothing
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (step && !advLdIn && !chipSel) |=> !st1.vld);
  // R12: sleep blocks new accesses
  a_r12_sleep_block: assert property (@(posedge clk) disable iff (!rstN)
    (step && zz) |=> !st1.vld);
  // R8: each enabled advance moves the beat counter by one
  a_r8_beat_count: assert property (@(posedge clk) disable iff (!rstN)
    (step && advLdIn) |=> (bCnt == $past(bCnt) + 2'd1));
endmodule

// File: rtl/nbs_dp.sv
module nbs_dp
  import nbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  logic [DATA_W-1:0] merged, rdHold, outReg;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.step && strb.wrEn && strb.wrLanes[g])
        laneMem[strb.wrAddr] <= dIn[g*LANE_W +: LANE_W];
    end
    // Coherency: late write data overrides the array for its lanes
    assign merged[g*LANE_W +: LANE_W] = (strb.fwdHit && strb.wrLanes[g]) ?
                                        dIn[g*LANE_W +: LANE_W] : laneMem[strb.rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHold <= '0;
      outReg <= '0;
    end else if (strb.step) begin
      if (strb.rdEn) rdHold <= merged;
      outReg <= rdHold;
    end
  end

  assign dOut = outReg;

  // R3: output register holds over a stalled edge
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(outReg));
  // R7: a forwarded lane takes the bus data of that edge
  a_r7_forward_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.rdEn && strb.fwdHit && strb.wrLanes[0])
      |=> (rdHold[LANE_W-1:0] == $past(dIn[LANE_W-1:0])));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import nbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advLdIn,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              cenN,
  input  logic              modeIlv,
  input  logic              oeN,
  input  logic              zz,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);
  strobe_t strb;

  nbs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .advLdIn(advLdIn), .weN(weN),
    .bwN(bwN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .cenN(cenN),
    .modeIlv(modeIlv), .zz(zz), .oeN(oeN), .strb(strb), .dOe(dOe)
  );

  nbs_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dIn(dIn), .dOut(dOut)
  );

  // R11: a high oeN always releases the bus
  always_comb begin
    if (rstN) a_r11_oe_gate: assert (!(oeN && dOe));
  end
endmodule

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;
  import nbs_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] addrIn;
  logic              advLdIn, weN, ce1N, ce2, ce3N, cenN, modeIlv, oeN, zz;
  logic [LANES-1:0]  bwN;
  logic [DATA_W-1:0] dIn, dOut;
  logic              dOe;

  pipe_sram u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .advLdIn(advLdIn), .weN(weN),
    .bwN(bwN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .cenN(cenN),
    .modeIlv(modeIlv), .oeN(oeN), .zz(zz), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  int compared = 0;
  int mismatched = 0;

  // Reference model: in-order memory plus two pending slots
  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } mop_t;

  logic [DATA_W-1:0] refMem [DEPTH];
  mop_t q1, q2;
  logic expOe;
  logic [DATA_W-1:0] expQ;
  logic [ADDR_W-1:0] mBase;
  logic [1:0] mStart, mCnt;
  logic mWr, mSel;

  task automatic check(string t, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic void modelEdge();
    mop_t n;
    logic [1:0] cn;
    if (cenN) return;
    expOe = 1'b0;
    if (q2.vld && q2.wr) begin
      for (int i = 0; i < LANES; i++)
        if (q2.lanes[i]) refMem[q2.addr][i*LANE_W +: LANE_W] = dIn[i*LANE_W +: LANE_W];
    end else if (q2.vld) begin
      expOe = 1'b1;
      expQ  = refMem[q2.addr];
    end
    cn = mCnt + 2'd1;
    n = '0;
    if (!advLdIn) begin
      n.vld = !ce1N && ce2 && !ce3N && !zz;
      n.wr  = !weN;
      n.addr = addrIn;
      mBase = addrIn; mStart = addrIn[1:0]; mCnt = 2'd0;
      mWr = !weN; mSel = n.vld;
    end else begin
      n.vld = mSel && !zz;
      n.wr  = mWr;
      n.addr = {mBase[ADDR_W-1:2], modeIlv ? (mStart ^ cn) : (mStart + cn)};
      mCnt = cn;
    end
    n.lanes = n.wr ? ~bwN : '0;
    q2 = q1;
    q1 = n;
  endfunction

  // Called at a falling edge after the inputs are set
  task automatic tick(string t);
    #1;
    check(t, DATA_W'(dOe), DATA_W'(expOe && !oeN));
    if (expOe) check(t, dOut, expQ);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic issue(logic ld, logic wr, logic [ADDR_W-1:0] a, logic [LANES-1:0] bw, string t);
    advLdIn = !ld; weN = !wr; addrIn = a; bwN = bw;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; cenN = 1'b0; zz = 1'b0;
    dIn = DATA_W'($urandom);
    tick(t);
  endtask

  task automatic idle(string t);
    advLdIn = 1'b0; ce1N = 1'b1; ce2 = 1'b0; ce3N = 1'b1; cenN = 1'b0; zz = 1'b0;
    dIn = DATA_W'($urandom);
    tick(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rstN = 1'b0; addrIn = '0; advLdIn = 1'b0; weN = 1'b1; bwN = '1;
    ce1N = 1'b1; ce2 = 1'b0; ce3N = 1'b1; cenN = 1'b0; modeIlv = 1'b0;
    oeN = 1'b0; zz = 1'b0; dIn = '0;
    q1 = '0; q2 = '0; expOe = 1'b0; expQ = '0;
    mBase = '0; mStart = '0; mCnt = '0; mWr = 1'b0; mSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 check("R13", DATA_W'(dOe), '0);
    @(negedge clk);

    // Fill every word (R2)
    for (int a = 0; a < DEPTH; a++) issue(1'b1, 1'b1, ADDR_W'(a), 2'b00, "R2");
    // Read a few back (R1)
    for (int a = 0; a < 6; a++) issue(1'b1, 1'b0, ADDR_W'(a), 2'b11, "R1");
    idle("R1"); idle("R1");

    // Forwarding with partial masks (R7)
    issue(1'b1, 1'b1, 6'd9, 2'b10, "R7");
    issue(1'b1, 1'b0, 6'd9, 2'b11, "R7");
    issue(1'b1, 1'b1, 6'd9, 2'b01, "R7");
    issue(1'b1, 1'b0, 6'd9, 2'b11, "R7");
    issue(1'b1, 1'b0, 6'd9, 2'b11, "R7");
    idle("R7"); idle("R7"); idle("R7");

    // Stalls mid-pipeline with toggling inputs (R3)
    issue(1'b1, 1'b1, 6'd12, 2'b00, "R3");
    issue(1'b1, 1'b0, 6'd12, 2'b11, "R3");
    for (int s = 0; s < 3; s++) begin
      cenN = 1'b1; addrIn = ADDR_W'($urandom); weN = $urandom; dIn = DATA_W'($urandom);
      advLdIn = $urandom; bwN = LANES'($urandom);
      tick("R3");
    end
    issue(1'b1, 1'b0, 6'd12, 2'b11, "R3");
    cenN = 1'b1; tick("R3");
    idle("R3"); idle("R3"); idle("R3");

    // Deselect patterns on write attempts (R4)
    for (int p = 0; p < 3; p++) begin
      advLdIn = 1'b0; weN = 1'b0; addrIn = 6'd20; bwN = 2'b00; cenN = 1'b0; zz = 1'b0;
      ce1N = (p == 0); ce2 = (p != 1); ce3N = (p == 2);
      dIn = DATA_W'($urandom);
      tick("R4");
      idle("R4");
      idle("R4");
    end
    issue(1'b1, 1'b0, 6'd20, 2'b11, "R4");
    idle("R4"); idle("R4"); idle("R4");

    // Sleep blocks writes, contents kept (R12)
    zz = 1'b1;
    advLdIn = 1'b0; weN = 1'b0; addrIn = 6'd21; bwN = 2'b00;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; dIn = DATA_W'($urandom);
    tick("R12");
    advLdIn = 1'b1; tick("R12");
    idle("R12"); idle("R12");
    issue(1'b1, 1'b0, 6'd21, 2'b11, "R12");
    issue(1'b1, 1'b0, 6'd22, 2'b11, "R12");
    idle("R12"); idle("R12"); idle("R12");

    // Linear and interleaved bursts, scrambled enables on advance (R8, R9, R10)
    for (int m = 0; m < 2; m++) begin
      modeIlv = m[0];
      issue(1'b1, 1'b1, 6'd30, 2'b00, "R10");
      for (int b = 0; b < 3; b++) begin
        advLdIn = 1'b1; weN = $urandom; ce1N = $urandom; ce2 = $urandom; ce3N = $urandom;
        bwN = LANES'($urandom); dIn = DATA_W'($urandom);
        tick("R10");
      end
      issue(1'b1, 1'b0, 6'd29, 2'b11, m == 0 ? "R8" : "R9");
      for (int b = 0; b < 3; b++) begin
        advLdIn = 1'b1; weN = $urandom; ce1N = 1'b1; ce2 = 1'b0;
        tick(m == 0 ? "R8" : "R9");
      end
      idle(m == 0 ? "R8" : "R9"); idle(m == 0 ? "R8" : "R9");
    end

    // oeN toggling over a read stream (R11)
    for (int b = 0; b < 6; b++) begin
      oeN = b[0];
      issue(1'b1, 1'b0, ADDR_W'(b), 2'b11, "R11");
    end
    oeN = 1'b1; idle("R11"); oeN = 1'b0; idle("R11"); idle("R11");

    // Seeded random mix (R1, R5, R6)
    for (int c = 0; c < 4000; c++) begin
      advLdIn = ($urandom % 10) < 3;
      weN     = $urandom;
      addrIn  = ($urandom % 2) ? ADDR_W'($urandom % 8) : ADDR_W'($urandom);
      bwN     = LANES'($urandom);
      if (($urandom % 100) < 85) begin
        ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
      end else begin
        ce1N = $urandom; ce2 = $urandom; ce3N = $urandom;
      end
      cenN    = ($urandom % 10) == 0;
      zz      = ($urandom % 25) == 0;
      modeIlv = $urandom;
      oeN     = ($urandom % 7) == 0;
      dIn     = DATA_W'($urandom);
      tick((c % 3) == 0 ? "R5" : ((c % 3) == 1 ? "R6" : "R1"));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule